// File: doc/BRIEF.md
# Crosspoint Parallel Command Controller

This block is the digital control plane for an eight-output by eight-input routing matrix. A host programs it through a narrow parallel port. The host sets an output address and a four-bit code, then raises a write strobe. The strobe counts only while an active-high enable is high and an active-low enable is low. The block keeps two route codes for every output: a pending code that writes fill, and an active code that drives the matrix. It also keeps an enable flag for every output.

The pending codes move into the active codes in one of two ways:

- **Edge mode:** on a rising edge of an external latch input.
- **Level mode:** continuously, for as long as that latch input is low.

Some codes do not touch the pending codes. These codes enable or disable one output or all outputs at once. A software-latch code copies all pending codes across, but only while the latch input is high.

The write strobe and the latch input arrive from outside the block's clock domain. Each passes through a two-flop synchronizer, and the block detects edges on the synchronized copies. The edge/level choice is a strap input that is held static. It may only change while reset is asserted.

Top module: `xbar_cmd_ctrl`

## Requirements
- R1: After reset, every enable flag is 0 and every active and pending code is 0 (all outputs on input 0).
- R2: A write acts only when `wr_i` rises while `ce_hi_i`=1 and `ce_lo_n_i`=0. With any other enable combination, the strobe changes no state.
- R3: Code values 0 to 7 store that input number as the pending code of the output named by `addr_i`. No other output's pending code changes.
- R4: Code 8 stores the grounded selection (value 8) as the pending code of the addressed output.
- R5: Codes 0 to 8 never change any enable flag.
- R6: Code 11 clears the addressed output's enable and code 12 sets it. This happens on the write itself, whatever the latch input and mode, and no pending code changes.
- R7: Code 13 clears all enables and code 14 sets all enables, on the write itself. No pending code changes.
- R8: Code 15 copies every pending code into its active code when the synchronized latch input is 1. When the latch input is 0, the code has no effect.
- R9: In edge mode (`edge_mode_i`=1), active codes load from pending codes only on a rising edge of the latch input, or through R8.
- R10: In level mode (`edge_mode_i`=0), active codes track pending codes while the latch input is 0, and hold while it is 1.
- R11: Codes 9 and 10 change no state.
- R12: The active code of output k appears on `route_o[4k+3:4k]`, and its enable flag appears on `out_en_o[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_i | input | 1 | Write strobe; acts on its rising edge |
| ce_hi_i | input | 1 | Active-high enable for the write strobe |
| ce_lo_n_i | input | 1 | Active-low enable for the write strobe |
| addr_i | input | ADDR_W (3) | Output address for route and single-output commands |
| code_i | input | 4 | Input number or command code |
| latch_i | input | 1 | Transfer control from pending to active codes |
| edge_mode_i | input | 1 | Static strap: 1 selects edge transfer, 0 selects level transfer |
| route_o | output | 4*N_OUT (32) | Active codes, 4 bits per output |
| out_en_o | output | N_OUT (8) | Enable flag per output |

## Verification
The bench builds the block with its defaults: N_OUT=8 and SYNC_STAGES=2. With these values the 3-bit address reaches every output and all 16 code values can be driven. The bench runs one phase in each transfer mode, with a reset between them. Each phase combines directed cases with seeded random writes, random enable combinations and latch toggles. This covers the corners below:

- pending codes that stay hidden in edge mode until a latch edge;
- the software latch with the latch input both low and high;
- reserved codes;
- writes that the chip enables block.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int CODE_W = 4;

    typedef logic [CODE_W-1:0] sel_code_t;

    localparam sel_code_t CODE_GND     = 4'd8;
    localparam sel_code_t CODE_DIS_ONE = 4'd11;
    localparam sel_code_t CODE_EN_ONE  = 4'd12;
    localparam sel_code_t CODE_DIS_ALL = 4'd13;
    localparam sel_code_t CODE_EN_ALL  = 4'd14;
    localparam sel_code_t CODE_SWLATCH = 4'd15;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ROUTE,
        OP_DIS_ONE,
        OP_EN_ONE,
        OP_DIS_ALL,
        OP_EN_ALL,
        OP_SWLATCH
    } op_e;

    typedef struct packed {
        op_e       op;
        sel_code_t val;
    } cmd_t;

endpackage

// File: rtl/xbar_sync.sv
module xbar_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/xbar_cmd_decode.sv
module xbar_cmd_decode
    import xbar_pkg::*;
(
    input  sel_code_t code_i,
    output cmd_t      cmd_o
);

    always_comb begin
        cmd_o.val = code_i;
        unique case (code_i)
            CODE_DIS_ONE: cmd_o.op = OP_DIS_ONE;
            CODE_EN_ONE:  cmd_o.op = OP_EN_ONE;
            CODE_DIS_ALL: cmd_o.op = OP_DIS_ALL;
            CODE_EN_ALL:  cmd_o.op = OP_EN_ALL;
            CODE_SWLATCH: cmd_o.op = OP_SWLATCH;
            4'd9, 4'd10:  cmd_o.op = OP_NONE;
            default:      cmd_o.op = (code_i <= CODE_GND) ? OP_ROUTE : OP_NONE;
        endcase
    end

endmodule

// File: rtl/xbar_route_store.sv
module xbar_route_store
    import xbar_pkg::*;
#(
    parameter int N_OUT  = 8,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_vld_i,
    input  cmd_t                     cmd_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     lat_lvl_i,
    input  logic                     lat_rise_i,
    input  logic                     edge_mode_i,
    output logic [N_OUT-1:0][CODE_W-1:0] slave_o,
    output logic [N_OUT-1:0]         en_o
);

    typedef struct packed {
        logic [N_OUT-1:0][CODE_W-1:0] master;
        logic [N_OUT-1:0][CODE_W-1:0] slave;
        logic [N_OUT-1:0]             en;
    } store_t;

    store_t st_d, st_q;
    logic   addr_ok;
    logic   swl;

    assign addr_ok = (int'(addr_i) < N_OUT);

    always_comb begin
        st_d = st_q;
        swl  = 1'b0;
        if (cmd_vld_i) begin
            unique case (cmd_i.op)
                OP_ROUTE:   if (addr_ok) st_d.master[addr_i] = cmd_i.val;
                OP_DIS_ONE: if (addr_ok) st_d.en[addr_i] = 1'b0;
                OP_EN_ONE:  if (addr_ok) st_d.en[addr_i] = 1'b1;
                OP_DIS_ALL: st_d.en = '0;
                OP_EN_ALL:  st_d.en = '1;
                OP_SWLATCH: swl = lat_lvl_i;
                default:    ;
            endcase
        end
        if (edge_mode_i) begin
            if (lat_rise_i || swl) st_d.slave = st_d.master;
        end else begin
            if (!lat_lvl_i || swl) st_d.slave = st_d.master;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slave_o = st_q.slave;
    assign en_o    = st_q.en;

endmodule

// File: rtl/xbar_cmd_ctrl.sv
module xbar_cmd_ctrl
    import xbar_pkg::*;
#(
    parameter int  N_OUT       = 8,
    parameter int  SYNC_STAGES = 2,
    localparam int ADDR_W      = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    localparam int ROUTE_W     = N_OUT * CODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               ce_hi_i,
    input  logic               ce_lo_n_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic               latch_i,
    input  logic               edge_mode_i,
    output logic [ROUTE_W-1:0] route_o,
    output logic [N_OUT-1:0]   out_en_o
);

    // bit 1: latch, bit 0: qualified write strobe
    logic [1:0] raw, sync, prev_d, prev_q, rise;
    cmd_t       cmd;
    logic [N_OUT-1:0][CODE_W-1:0] slave;

    assign raw = {latch_i, wr_i & ce_hi_i & ~ce_lo_n_i};

    xbar_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (sync)
    );

    always_comb begin
        prev_d = sync;
        rise   = sync & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    xbar_cmd_decode dec_i (
        .code_i (code_i),
        .cmd_o  (cmd)
    );

    xbar_route_store #(.N_OUT(N_OUT), .ADDR_W(ADDR_W)) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_vld_i   (rise[0]),
        .cmd_i       (cmd),
        .addr_i      (addr_i),
        .lat_lvl_i   (sync[1]),
        .lat_rise_i  (rise[1]),
        .edge_mode_i (edge_mode_i),
        .slave_o     (slave),
        .en_o        (out_en_o)
    );

    assign route_o = slave;

endmodule

// File: rtl/xbar_cmd_ctrl_chk.sv
module xbar_cmd_ctrl_chk #(
    parameter int N_OUT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_i,
    input logic               ce_hi_i,
    input logic               ce_lo_n_i,
    input logic               latch_i,
    input logic               edge_mode_i,
    input logic [N_OUT*4-1:0] route_o,
    input logic [N_OUT-1:0]   out_en_o
);

    logic [2:0] warm_q;
    logic       warm;
    logic       sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= '0;
        else if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
    end

    assign warm = (warm_q >= 3'd4);
    assign sel  = wr_i & ce_hi_i & ~ce_lo_n_i;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (out_en_o == '0 && route_o == '0));

    // R2: no qualified strobe for four samples leaves enables alone
    a_r2_idle_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !sel && !$past(sel) && !$past(sel, 2) && !$past(sel, 3))
        |=> $stable(out_en_o));

    // R6/R7: an enable change touches one flag or sets all to one value
    a_r6_en_change_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_en_o != $past(out_en_o))
        |-> ($countones(out_en_o ^ $past(out_en_o)) == 1
             || out_en_o == '0 || out_en_o == '1));

    // R9: edge mode with latch low throughout keeps active codes
    a_r9_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && edge_mode_i && !latch_i && !$past(latch_i)
         && !$past(latch_i, 2) && !$past(latch_i, 3))
        |=> $stable(route_o));

    // R10: level mode with latch high and no writes keeps active codes
    a_r10_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !edge_mode_i && latch_i && $past(latch_i)
         && $past(latch_i, 2) && $past(latch_i, 3)
         && !sel && !$past(sel) && !$past(sel, 2) && !$past(sel, 3))
        |=> $stable(route_o));

endmodule

bind xbar_cmd_ctrl xbar_cmd_ctrl_chk #(.N_OUT(N_OUT)) chk_i (.*);

// File: tb/xbar_cmd_ctrl_tb.sv
module xbar_cmd_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_i = 1'b0;
    logic        ce_hi_i = 1'b1;
    logic        ce_lo_n_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [3:0]  code_i = '0;
    logic        latch_i = 1'b0;
    logic        edge_mode_i = 1'b0;
    logic [31:0] route_o;
    logic [7:0]  out_en_o;

    int nchk = 0;
    int nerr = 0;

    logic [3:0] m [8];
    logic [3:0] s [8];
    logic [7:0] en;
    logic       lat;
    logic       mode;

    always #2 clk = ~clk;

    xbar_cmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .ce_hi_i(ce_hi_i),
        .ce_lo_n_i(ce_lo_n_i), .addr_i(addr_i), .code_i(code_i),
        .latch_i(latch_i), .edge_mode_i(edge_mode_i),
        .route_o(route_o), .out_en_o(out_en_o)
    );

    function automatic logic [31:0] exp_route();
        logic [31:0] r;
        for (int k = 0; k < 8; k++) r[4*k +: 4] = s[k];
        return r;
    endfunction

    task automatic check(input string tag);
        nchk++;
        if (route_o !== exp_route() || out_en_o !== en) begin
            nerr++;
            $display("FAIL %s route=%h exp=%h en=%b exp=%b",
                     tag, route_o, exp_route(), out_en_o, en);
        end
    endtask

    task automatic do_reset(input logic md);
        @(negedge clk);
        rst_n = 1'b0; edge_mode_i = md; latch_i = 1'b0; wr_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        for (int k = 0; k < 8; k++) begin m[k] = '0; s[k] = '0; end
        en = '0; lat = 1'b0; mode = md;
        check("R1 reset");
    endtask

    task automatic do_write(input logic [2:0] a, input logic [3:0] c,
                            input logic hi, input logic lo_n, input string tag);
        @(negedge clk);
        addr_i = a; code_i = c; ce_hi_i = hi; ce_lo_n_i = lo_n;
        @(negedge clk);
        wr_i = 1'b1;
        repeat (4) @(negedge clk);
        wr_i = 1'b0;
        repeat (5) @(negedge clk);
        if (hi && !lo_n) begin
            if (c <= 4'd8)       m[a] = c;
            else if (c == 4'd11) en[a] = 1'b0;
            else if (c == 4'd12) en[a] = 1'b1;
            else if (c == 4'd13) en = '0;
            else if (c == 4'd14) en = '1;
            else if (c == 4'd15 && lat) for (int k = 0; k < 8; k++) s[k] = m[k];
        end
        if (!mode && !lat) for (int k = 0; k < 8; k++) s[k] = m[k];
        ce_hi_i = 1'b1; ce_lo_n_i = 1'b0;
        check(tag);
    endtask

    task automatic set_latch(input logic v, input string tag);
        @(negedge clk);
        latch_i = v;
        repeat (6) @(negedge clk);
        if ((mode && !lat && v) || (!mode && !v))
            for (int k = 0; k < 8; k++) s[k] = m[k];
        lat = v;
        check(tag);
    endtask

    function automatic string code_tag(input logic [3:0] c, input logic ok);
        if (!ok) return "R2 blocked";
        if (c < 4'd8) return "R3 route";
        if (c == 4'd8) return "R4 ground";
        if (c == 4'd9 || c == 4'd10) return "R11 reserved";
        if (c == 4'd11 || c == 4'd12) return "R6 single en";
        if (c == 4'd13 || c == 4'd14) return "R7 all en";
        return "R8 swlatch";
    endfunction

    task automatic random_phase(input int n);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 9) < 7) begin
                logic [2:0] a;
                logic [3:0] c;
                logic hi, lo_n;
                int k;
                a = 3'($urandom_range(0, 7));
                c = 4'($urandom_range(0, 15));
                k = $urandom_range(0, 5);
                hi = (k != 0);
                lo_n = (k == 1);
                do_write(a, c, hi, lo_n, code_tag(c, hi && !lo_n));
            end else begin
                set_latch(~lat, mode ? "R9 latch" : "R10 latch");
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // level mode, latch low: pending codes flow straight through
        do_reset(1'b0);
        do_write(3'd3, 4'd5, 1'b1, 1'b0, "R3 out3<-in5");
        nchk++;
        if (route_o[15:12] !== 4'd5) begin
            nerr++;
            $display("FAIL R12 field=%h exp=5", route_o[15:12]);
        end
        do_write(3'd0, 4'd14, 1'b0, 1'b0, "R2 hi enable low");
        do_write(3'd0, 4'd14, 1'b1, 1'b1, "R2 lo enable high");
        do_write(3'd6, 4'd8, 1'b1, 1'b0, "R4 ground out6");
        do_write(3'd6, 4'd2, 1'b1, 1'b0, "R5 route keeps en");
        do_write(3'd2, 4'd12, 1'b1, 1'b0, "R6 enable out2");
        do_write(3'd2, 4'd11, 1'b1, 1'b0, "R6 disable out2");
        do_write(3'd0, 4'd14, 1'b1, 1'b0, "R7 enable all");
        do_write(3'd1, 4'd9, 1'b1, 1'b0, "R11 code9");
        do_write(3'd1, 4'd10, 1'b1, 1'b0, "R11 code10");
        set_latch(1'b1, "R10 latch high");
        do_write(3'd7, 4'd4, 1'b1, 1'b0, "R10 held while high");
        set_latch(1'b0, "R10 latch low");
        do_write(3'd0, 4'd13, 1'b1, 1'b0, "R7 disable all");
        random_phase(180);

        // edge mode
        do_reset(1'b1);
        do_write(3'd2, 4'd6, 1'b1, 1'b0, "R9 hidden until edge");
        do_write(3'd0, 4'd15, 1'b1, 1'b0, "R8 nop latch low");
        set_latch(1'b1, "R9 rising edge");
        do_write(3'd2, 4'd7, 1'b1, 1'b0, "R9 hidden while high");
        do_write(3'd0, 4'd15, 1'b1, 1'b0, "R8 copy latch high");
        set_latch(1'b0, "R9 falling no load");
        do_write(3'd5, 4'd12, 1'b1, 1'b0, "R6 enable out5 edge");
        random_phase(180);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule